// File: doc/BRIEF.md
# Timer Counter with Single Compare Output

This block is a free-running counter with one compare channel. A single-cycle `tick` input is its timer clock: on each tick the counter advances according to the selected waveform mode. The counter's value is compared against an active compare register. A match raises a sticky flag and drives a waveform bit according to a two-bit output-action field.

The compare value is double buffered in the two PWM modes. Software writes land in a staging register there, and the active register takes the staged value only at the count extreme, so pulses stay whole. In the non-PWM modes, writes reach the active register at once. Software can force an output action without a real match in the non-PWM modes. Any write to the counter suppresses the compare on the next tick.

Top module: `tmr_cmp_unit`

## Requirements
- R1: In waveform mode 00 (normal) the counter increments by one per tick and wraps from all-ones to zero. A tick taken while the counter equals the active compare value sets `match_flag` on that clock edge. `flag_clr` clears the flag, and a new match wins over a clear in the same cycle.
- R2: In waveform mode 10 (clear on match), a matching tick loads zero into the counter instead of incrementing it.
- R3: In waveform mode 11 (fast PWM) the counter counts up and wraps to zero. With output action 10, a match clears the waveform bit and the wrap to zero sets it. Output action 11 inverts both.
- R4: In waveform mode 01 (phase-correct PWM) the counter counts up to all-ones, then down to zero, then up again, with no repeated value at the turning points. With output action 10, a match while counting up clears the waveform bit and a match while counting down sets it. Output action 11 inverts both.
- R5: In the PWM modes (01 and 11) a compare write goes to a staging register, and `cmp_rd` returns the staged value. The active compare register takes the staged value on the tick at which the counter stands at all-ones, and at no other time.
- R6: In modes 00 and 10 a compare write updates the active compare register directly, and `cmp_rd` returns it.
- R7: In modes 00 and 10 a `force_cmp` pulse applies the output action as a real match would. It leaves the flag and the counter untouched. In the PWM modes `force_cmp` has no effect.
- R8: A counter write suppresses the compare on the next tick, however many idle cycles come first.
- R9: The output action takes effect in the cycle after it is written. Action 00 holds `wave_out` low. The waveform bit keeps its value across waveform mode changes and reappears when an action other than 00 is selected.
- R10: In modes 00 and 10, a match with output action 01 toggles the waveform bit, action 10 clears it, and action 11 sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock enable, one cycle per count |
| cnt_wr | input | 1 | Write `wdata` into the counter |
| cmp_wr | input | 1 | Write `wdata` into the compare path |
| ctl_wr | input | 1 | Load waveform mode and output action |
| wave_mode_in | input | 2 | Waveform mode: 00 normal, 01 phase-correct, 10 clear on match, 11 fast PWM |
| out_mode_in | input | 2 | Output action: 00 off, 01 toggle, 10 clear, 11 set |
| force_cmp | input | 1 | Force an output action (non-PWM modes) |
| flag_clr | input | 1 | Clear the match flag |
| wdata | input | WIDTH | Write data for the counter and compare |
| count | output | WIDTH | Current counter value |
| cmp_rd | output | WIDTH | Compare readback (staged value in PWM modes) |
| match_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Waveform output |

## Verification
The bench builds the block with WIDTH set to 4, so a full count period is 16 ticks. This puts wrap-around, the turning points of the phase-correct sweep and the staging-register load at all-ones within a few directed ticks. The narrow width lets the bench follow a counter through a whole up and down sweep and check the exact tick at which each match, reload and output edge lands.

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic             cmp_wr,
  input  logic             ctl_wr,
  input  logic [1:0]       wave_mode_in,
  input  logic [1:0]       out_mode_in,
  input  logic             force_cmp,
  input  logic             flag_clr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] cmp_rd,
  output logic             match_flag,
  output logic             wave_out
);
  localparam logic [WIDTH-1:0] MAXV = '1;
  localparam logic [1:0] M_NORM = 2'b00, M_PC = 2'b01, M_CTC = 2'b10, M_FAST = 2'b11;

  logic [1:0]       wave_mode, out_mode;
  logic [WIDTH-1:0] cnt_q, cnt_nx, cmp_act, cmp_buf;
  logic             dn_q, dn_nx, blk_q, oc_q, oc_nx, flag_q;

  wire pwm    = wave_mode[0];
  wire at_max = (cnt_q == MAXV);
  wire hit    = tick && !blk_q && !cnt_wr && (cnt_q == cmp_act);
  wire load   = tick && pwm && at_max;
  wire bottom = tick && !cnt_wr && at_max && (wave_mode == M_FAST);

  always_comb begin
    cnt_nx = cnt_q;
    dn_nx  = dn_q;
    if (cnt_wr) cnt_nx = wdata;
    else if (tick) begin
      case (wave_mode)
        M_CTC: cnt_nx = hit ? '0 : cnt_q + 1'b1;
        M_PC: begin
          if (!dn_q) begin
            if (at_max) begin dn_nx = 1'b1; cnt_nx = MAXV - 1'b1; end
            else cnt_nx = cnt_q + 1'b1;
          end else begin
            if (cnt_q == '0) begin dn_nx = 1'b0; cnt_nx = {{(WIDTH-1){1'b0}}, 1'b1}; end
            else cnt_nx = cnt_q - 1'b1;
          end
        end
        default: cnt_nx = cnt_q + 1'b1;
      endcase
    end
    if (wave_mode != M_PC) dn_nx = 1'b0;
  end

  always_comb begin
    oc_nx = oc_q;
    if (!pwm) begin
      if (hit || force_cmp)
        case (out_mode)
          2'b01:   oc_nx = ~oc_q;
          2'b10:   oc_nx = 1'b0;
          2'b11:   oc_nx = 1'b1;
          default: oc_nx = oc_q;
        endcase
    end else begin
      if (hit && out_mode[1])
        oc_nx = out_mode[0] ^ ((wave_mode == M_PC) && dn_q);
      if (bottom && out_mode[1])
        oc_nx = ~out_mode[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wave_mode <= M_NORM;
      out_mode  <= 2'b00;
      cnt_q     <= '0;
      dn_q      <= 1'b0;
      blk_q     <= 1'b0;
      oc_q      <= 1'b0;
      flag_q    <= 1'b0;
      cmp_act   <= '0;
      cmp_buf   <= '0;
    end else begin
      if (ctl_wr) begin
        wave_mode <= wave_mode_in;
        out_mode  <= out_mode_in;
      end
      cnt_q <= cnt_nx;
      dn_q  <= dn_nx;
      oc_q  <= oc_nx;
      if (cnt_wr)    blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (cmp_wr) cmp_buf <= wdata;
      if (cmp_wr && !pwm) cmp_act <= wdata;
      else if (load)      cmp_act <= cmp_buf;
    end
  end

  assign count      = cnt_q;
  assign cmp_rd     = pwm ? cmp_buf : cmp_act;
  assign match_flag = flag_q;
  assign wave_out   = (out_mode != 2'b00) && oc_q;

  // R1
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !blk_q && !cnt_wr && cnt_q == cmp_act) |=> match_flag);
  // R2
  ctc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == M_CTC && tick && !blk_q && !cnt_wr && cnt_q == cmp_act) |=> count == '0);
  // R3
  fast_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == M_FAST && tick && !cnt_wr && at_max) |=> count == '0);
  // R4
  pc_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_mode == M_PC && tick && !cnt_wr && !dn_q && at_max) |=> (count == MAXV - 1'b1 && dn_q));
  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !(tick && at_max)) |=> $stable(cmp_act));
  // R7
  force_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && !pwm && !tick && !cnt_wr) |=> $stable(count));
  // R7
  force_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_cmp && pwm && !tick && !ctl_wr) |=> $stable(oc_q));
  // R8
  block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && tick && !match_flag) |=> !match_flag);
endmodule

// File: tb/test_tmr_cmp_unit.sv
module test_tmr_cmp_unit;
  localparam int W = 4;
  logic clk = 0, rst_n = 0;
  logic tick = 0, cnt_wr = 0, cmp_wr = 0, ctl_wr = 0, force_cmp = 0, flag_clr = 0;
  logic [1:0] wave_mode_in = 0, out_mode_in = 0;
  logic [W-1:0] wdata = 0;
  logic [W-1:0] count, cmp_rd;
  logic match_flag, wave_out;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tmr_cmp_unit #(.WIDTH(W)) i_tmr_cmp_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cmp_wr(cmp_wr),
    .ctl_wr(ctl_wr), .wave_mode_in(wave_mode_in), .out_mode_in(out_mode_in),
    .force_cmp(force_cmp), .flag_clr(flag_clr), .wdata(wdata), .count(count),
    .cmp_rd(cmp_rd), .match_flag(match_flag), .wave_out(wave_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tk(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask
  task automatic ctl(input logic [1:0] m, input logic [1:0] o);
    @(negedge clk); ctl_wr = 1; wave_mode_in = m; out_mode_in = o;
    @(negedge clk); ctl_wr = 0;
  endtask
  task automatic wr_cnt(input int v);
    @(negedge clk); cnt_wr = 1; wdata = W'(v);
    @(negedge clk); cnt_wr = 0;
  endtask
  task automatic wr_cmp(input int v);
    @(negedge clk); cmp_wr = 1; wdata = W'(v);
    @(negedge clk); cmp_wr = 0;
  endtask
  task automatic frc();
    @(negedge clk); force_cmp = 1;
    @(negedge clk); force_cmp = 0;
  endtask
  task automatic fclr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset count", count, 0);
    chk("R1 reset flag", match_flag, 0);
    chk("R9 reset wave", wave_out, 0);
    chk("R6 reset cmp", cmp_rd, 0);
  endtask

  task automatic t_normal();
    ctl(2'b00, 2'b01);
    wr_cmp(5);
    chk("R6 direct cmp", cmp_rd, 5);
    wr_cnt(0);
    tk(5);
    chk("R1 count", count, 5);
    chk("R1 no early flag", match_flag, 0);
    tk(1);
    chk("R1 flag on match", match_flag, 1);
    chk("R1 count after", count, 6);
    chk("R10 toggle", wave_out, 1);
    wr_cnt(14);
    tk(2);
    chk("R1 wrap", count, 0);
    fclr();
    chk("R1 flag clear", match_flag, 0);
  endtask

  task automatic t_block();
    wr_cnt(5);
    repeat (3) @(negedge clk);
    tk(1);
    chk("R8 count moved", count, 6);
    chk("R8 flag blocked", match_flag, 0);
    chk("R8 wave kept", wave_out, 1);
  endtask

  task automatic t_force();
    ctl(2'b00, 2'b10);
    frc();
    chk("R7 force clear", wave_out, 0);
    chk("R7 no flag", match_flag, 0);
    chk("R7 count kept", count, 6);
    ctl(2'b00, 2'b11);
    frc();
    chk("R7 force set", wave_out, 1);
    chk("R7 count kept2", count, 6);
  endtask

  task automatic t_clear_match();
    ctl(2'b00, 2'b10);
    wr_cnt(3);
    tk(3);
    chk("R10 clear on match", wave_out, 0);
    chk("R10 flag", match_flag, 1);
    fclr();
  endtask

  task automatic t_ctc();
    ctl(2'b10, 2'b01);
    wr_cmp(3);
    chk("R6 ctc direct", cmp_rd, 3);
    wr_cnt(0);
    tk(3);
    chk("R2 count", count, 3);
    tk(1);
    chk("R2 cleared", count, 0);
    chk("R2 flag", match_flag, 1);
    chk("R10 ctc toggle", wave_out, 1);
    fclr();
    ctl(2'b10, 2'b00);
    chk("R9 off", wave_out, 0);
    ctl(2'b10, 2'b11);
    chk("R9 kept", wave_out, 1);
  endtask

  task automatic t_fast();
    ctl(2'b00, 2'b10);
    frc();
    wr_cmp(3);
    ctl(2'b11, 2'b10);
    chk("R3 pre wave", wave_out, 0);
    wr_cmp(4);
    chk("R5 staged read", cmp_rd, 4);
    wr_cnt(15);
    tk(1);
    chk("R3 wrap", count, 0);
    chk("R3 bottom set", wave_out, 1);
    tk(4);
    chk("R5 old value unused", wave_out, 1);
    chk("R5 count", count, 4);
    tk(1);
    chk("R3 match clear", wave_out, 0);
    chk("R3 flag", match_flag, 1);
    fclr();
    wr_cmp(9);
    tk(5);
    chk("R5 staged not active", match_flag, 0);
    chk("R5 count9", count, 10);
  endtask

  task automatic t_phase();
    ctl(2'b00, 2'b11);
    frc();
    ctl(2'b00, 2'b10);
    wr_cmp(5);
    ctl(2'b01, 2'b10);
    chk("R4 pre wave", wave_out, 1);
    wr_cnt(2);
    tk(3);
    chk("R4 count", count, 5);
    tk(1);
    chk("R4 up clear", wave_out, 0);
    chk("R4 count up", count, 6);
    tk(9);
    chk("R4 top", count, 15);
    tk(1);
    chk("R4 turn", count, 14);
    fclr();
    tk(9);
    chk("R4 down", count, 5);
    tk(1);
    chk("R4 down set", wave_out, 1);
    chk("R4 count down", count, 4);
    frc();
    chk("R7 pwm force ignored", wave_out, 1);
    ctl(2'b00, 2'b10);
    chk("R9 mode change keeps", wave_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_block();
    t_force();
    t_clear_match();
    t_ctc();
    t_fast();
    t_phase();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule